// File: doc/BRIEF.md
# Serial Audio Transmit Shifter

This block takes parallel audio words from a holding register and sends them out one bit at a time, paced by an external bit clock and framed by an external frame-sync input. A host or DMA engine writes each word into the holding register. The block raises a request whenever that register is empty. A configuration word sets the size of each of the two word slots in a frame, whether there are one or two words per frame, whether the first bit starts on the sync or one bit clock later, and whether a frame sync that arrives inside a frame is ignored or restarts the frame. A polarity input picks which bit-clock edge launches data.

Everything runs on the system clock. The bit clock and frame sync are sampled, and all shifting happens on the selected bit-clock edge. Serial data is held at 0 while the transmitter is in reset, and whenever no data bit is active. A sync that finds no data ready sets a sticky error flag, and an unexpected sync inside a frame can set it too. The flag clears only when the transmitter goes back into reset. A halt input freezes the shifter unless free-run is set.

The controller has five states:
- `ST_IDLE`: in reset, output quiet.
- `ST_ARMED`: out of reset and waiting for the first sync.
- `ST_DELAY`: the one-bit gap after a sync.
- `ST_SHIFT`: data bits being driven.
- `ST_GAP`: frame done, waiting for the next sync.

The transitions are:
- IDLE to ARMED on the first clock with the transmitter released.
- ARMED or GAP to DELAY or SHIFT on an accepted sync.
- DELAY to SHIFT on the next launch edge.
- SHIFT to SHIFT when the second slot starts, or on a restarting sync.
- SHIFT to DELAY on a restarting sync when the one-bit delay is selected.
- SHIFT to GAP after the last bit of the frame.
- Any state to IDLE when the transmitter is put back into reset.

Top module: `audio_tx_shifter`

## Requirements
- R1: While `tx_run` is 0, the state is idle, `sdata` is 0 and `sync_err` is 0. This holds from the clock edge after `tx_run` falls.
- R2: Word sizes come from a 3-bit code: 0=8, 1=12, 2=16, 3=20, 4=24, and 5 to 7 = 32 bits. The first-slot code is at `tx_cfg[7:5]` and the second-slot code is at `tx_cfg[23:21]`. Bits go out MSB first, starting from bit size-1 of the written word. Higher bits are ignored.
- R3: `tx_cfg[17:16]` selects the data delay. With 0, the first data bit is launched on the edge that sees the frame-sync rising edge. With any other value, a 0 is driven on that edge and the first bit follows on the next launch edge.
- R4: `tx_cfg[14:8]` holds words per frame minus one. With 0, one word is sent per frame. With any other value, two words are sent back to back, the second using the second-slot size. After the last bit, `sdata` returns to 0 on the next launch edge.
- R5: With `clk_pol` set to 1, bits are launched on falling edges of `bclk`. With 0, they are launched on rising edges. Frame sync is sampled on the launch edge.
- R6: `req` is 1 exactly when `tx_run` is 1 and the holding register is empty. A write sets the register full. Loading a slot empties it unless a write happens in the same cycle, in which case the write is kept.
- R7: If a slot starts while the holding register is empty, the last word loaded is sent again.
- R8: `sync_err` is set, and stays set, when a sync is accepted with the holding register empty, or when a sync restarts a frame. It clears only when `tx_run` is 0.
- R9: A frame-sync rising edge inside a frame restarts the frame when `tx_cfg[18]` is 0. When `tx_cfg[18]` is 1, that edge has no effect.
- R10: While `halt_in` is 1 and `free_run` is 0, no bit-clock edge is acted on and `sdata` and `sync_err` hold. With `free_run` set to 1, `halt_in` has no effect.
- R11: `sdata` is 0 during the delay bit, the idle state and the gap between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bit clock, synchronous to clk |
| fsync | input | 1 | Frame sync, active high |
| tx_cfg | input | 32 | Transmit configuration word |
| tx_run | input | 1 | Transmitter release, 0 holds the shifter in reset |
| clk_pol | input | 1 | 1 launches on falling bclk, 0 on rising bclk |
| free_run | input | 1 | 1 makes halt_in have no effect |
| halt_in | input | 1 | Halt request |
| wr_en | input | 1 | Holding-register write strobe |
| wr_data | input | 32 | Word to send, right aligned |
| sdata | output | 1 | Serial data |
| req | output | 1 | Data request, holding register empty |
| sync_err | output | 1 | Sticky frame-sync error |

## Verification
The bench builds the block with its default 32-bit data width. This makes every size code reachable, including the 32-bit one. It also lets the bench write words whose unused high bits are full of noise, so any leak of those bits would show on the line. Two slots of different sizes, both delay settings, both clock polarities, starved frames, restarting and ignored early syncs, and a halt window are all compared clock by clock against a bit-queue model.

// File: rtl/sat_pkg.sv
package sat_pkg;

    parameter int SAT_DW = 32;
    localparam int SAT_CFG_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_DELAY,
        ST_SHIFT,
        ST_GAP
    } sat_state_t;

    typedef struct packed {
        logic [2:0] len_a;
        logic [2:0] len_b;
        logic       two_words;
        logic       one_bit_delay;
        logic       ignore_fs;
    } sat_cfg_t;

    function automatic int word_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 8;
            3'd1:    return 12;
            3'd2:    return 16;
            3'd3:    return 20;
            3'd4:    return 24;
            default: return 32;
        endcase
    endfunction

    function automatic sat_cfg_t decode_cfg(input logic [SAT_CFG_W-1:0] w);
        sat_cfg_t c;
        c.len_a         = w[7:5];
        c.len_b         = w[23:21];
        c.two_words     = |w[14:8];
        c.one_bit_delay = |w[17:16];
        c.ignore_fs     = w[18];
        return c;
    endfunction

endpackage

// File: rtl/sat_edge.sv
module sat_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    input  logic clk_pol,
    input  logic halt_in,
    input  logic free_run,
    output logic adv,
    output logic fs_edge
);

    logic bclk_q;
    logic fs_q;
    logic rise;
    logic fall;
    logic tick;
    logic frozen;

    assign rise    = bclk & ~bclk_q;
    assign fall    = ~bclk & bclk_q;
    assign tick    = clk_pol ? fall : rise;
    assign frozen  = halt_in & ~free_run;
    assign adv     = tick & ~frozen;
    assign fs_edge = fsync & ~fs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
        end else begin
            bclk_q <= bclk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q <= 1'b0;
        end else if (adv) begin
            fs_q <= fsync;
        end
    end

endmodule

// File: rtl/sat_hold.sv
module sat_hold #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic [DW-1:0] word,
    output logic          full
);

    logic [DW-1:0] hold_q;
    logic [DW-1:0] last_q;
    logic          full_q;

    assign word = full_q ? hold_q : last_q;
    assign full = full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr_en) begin
            hold_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else if (wr_en) begin
            full_q <= 1'b1;
        end else if (take) begin
            full_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (take) begin
            last_q <= word;
        end
    end

endmodule

// File: rtl/sat_fsm.sv
module sat_fsm
    import sat_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = $clog2(DW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          adv,
    input  logic          fs_edge,
    input  sat_cfg_t      cfg,
    input  logic          hold_full,
    input  logic [DW-1:0] word,
    output logic          take,
    output logic          sdata,
    output logic          sync_err,
    output sat_state_t    state
);

    sat_state_t    state_q;
    sat_state_t    state_d;
    logic [DW-1:0] shreg_q;
    logic [CW-1:0] cnt_q;
    logic          slot_q;
    logic          sdata_q;
    logic          err_q;

    logic          in_frame;
    logic          waiting;
    logic          act;
    logic          accept;
    logic          load_a;
    logic          load_b;
    logic          step;
    logic          finish;
    logic          err_set;
    logic [CW-1:0] len_a;
    logic [CW-1:0] len_b;
    logic [CW-1:0] cur_len;
    logic [DW-1:0] aligned;

    assign len_a    = CW'(word_bits(cfg.len_a));
    assign len_b    = CW'(word_bits(cfg.len_b));
    assign in_frame = (state_q == ST_DELAY) || (state_q == ST_SHIFT);
    assign waiting  = (state_q == ST_ARMED) || (state_q == ST_GAP);
    assign act      = adv & run;
    assign accept   = act & fs_edge & (waiting | (in_frame & ~cfg.ignore_fs));
    assign load_a   = (accept & ~cfg.one_bit_delay)
                    | (act & (state_q == ST_DELAY) & ~accept);
    assign load_b   = act & (state_q == ST_SHIFT) & ~accept & (cnt_q == '0)
                    & ~slot_q & cfg.two_words;
    assign step     = act & (state_q == ST_SHIFT) & ~accept & (cnt_q != '0);
    assign finish   = act & (state_q == ST_SHIFT) & ~accept & (cnt_q == '0)
                    & ~load_b;
    assign err_set  = accept & (~hold_full | in_frame);
    assign take     = load_a | load_b;
    assign cur_len  = load_b ? len_b : len_a;
    assign aligned  = word << (CW'(DW) - cur_len);

    assign sdata    = sdata_q;
    assign sync_err = err_q;
    assign state    = state_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                state_d = ST_ARMED;
            end
            ST_ARMED, ST_GAP: begin
                if (accept) begin
                    state_d = cfg.one_bit_delay ? ST_DELAY : ST_SHIFT;
                end
            end
            ST_DELAY: begin
                if (accept && cfg.one_bit_delay) begin
                    state_d = ST_DELAY;
                end else if (load_a) begin
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (accept) begin
                    state_d = cfg.one_bit_delay ? ST_DELAY : ST_SHIFT;
                end else if (finish) begin
                    state_d = ST_GAP;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
        if (!run) begin
            state_d = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            slot_q  <= 1'b0;
            sdata_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (!run) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            slot_q  <= 1'b0;
            sdata_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (err_set) begin
                err_q <= 1'b1;
            end
            if (accept && cfg.one_bit_delay) begin
                sdata_q <= 1'b0;
                slot_q  <= 1'b0;
            end
            if (take) begin
                sdata_q <= aligned[DW-1];
                shreg_q <= aligned << 1;
                cnt_q   <= cur_len - CW'(1);
                slot_q  <= load_b;
            end
            if (step) begin
                sdata_q <= shreg_q[DW-1];
                shreg_q <= shreg_q << 1;
                cnt_q   <= cnt_q - CW'(1);
            end
            if (finish) begin
                sdata_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/audio_tx_shifter.sv
module audio_tx_shifter
    import sat_pkg::*;
#(
    parameter int DW = SAT_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bclk,
    input  logic          fsync,
    input  logic [31:0]   tx_cfg,
    input  logic          tx_run,
    input  logic          clk_pol,
    input  logic          free_run,
    input  logic          halt_in,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          sdata,
    output logic          req,
    output logic          sync_err
);

    localparam int CW = $clog2(DW + 1);

    sat_cfg_t      cfg;
    logic          adv;
    logic          fs_edge;
    logic          take;
    logic          hold_full;
    logic [DW-1:0] word;
    sat_state_t    fsm_state;
    logic          unused_sink;

    assign cfg         = decode_cfg(tx_cfg);
    assign req         = tx_run & ~hold_full;
    assign unused_sink = ^{tx_cfg[31:24], tx_cfg[20:19], tx_cfg[15],
                           tx_cfg[4:0], fsm_state};

    sat_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk     (bclk),
        .fsync    (fsync),
        .clk_pol  (clk_pol),
        .halt_in  (halt_in),
        .free_run (free_run),
        .adv      (adv),
        .fs_edge  (fs_edge)
    );

    sat_hold #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .word    (word),
        .full    (hold_full)
    );

    sat_fsm #(.DW(DW), .CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (tx_run),
        .adv       (adv),
        .fs_edge   (fs_edge),
        .cfg       (cfg),
        .hold_full (hold_full),
        .word      (word),
        .take      (take),
        .sdata     (sdata),
        .sync_err  (sync_err),
        .state     (fsm_state)
    );

endmodule

// File: rtl/sat_checker.sv
module sat_checker
    import sat_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tx_run,
    input logic       halt_in,
    input logic       free_run,
    input logic       wr_en,
    input logic       sdata,
    input logic       req,
    input logic       sync_err,
    input sat_state_t fsm_state
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_run |=> (sdata == 1'b0 && !sync_err)); // R1

    AST_REQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !req); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_run && sync_err) |=> sync_err); // R8

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_in && !free_run && tx_run) |=> ($stable(sdata) && $stable(sync_err))); // R10

    AST_SILENT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_ARMED || fsm_state == ST_GAP || fsm_state == ST_DELAY)
        |-> (sdata == 1'b0)); // R11

endmodule

bind audio_tx_shifter sat_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_run    (tx_run),
    .halt_in   (halt_in),
    .free_run  (free_run),
    .wr_en     (wr_en),
    .sdata     (sdata),
    .req       (req),
    .sync_err  (sync_err),
    .fsm_state (fsm_state)
);

// File: tb/audio_tx_shifter_test.sv
`timescale 1ns/1ps
module audio_tx_shifter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        fsync = 1'b0;
    logic [31:0] tx_cfg = '0;
    logic        tx_run = 1'b0;
    logic        clk_pol = 1'b1;
    logic        free_run = 1'b0;
    logic        halt_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        sdata;
    logic        req;
    logic        sync_err;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur = "R1";
    bit    cmp_on = 1'b0;
    bit    feed_on = 1'b0;
    bit    done = 1'b0;
    logic [31:0] feed_q[$];

    always #5 clk = ~clk;

    audio_tx_shifter uut (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .tx_cfg(tx_cfg),
        .tx_run(tx_run), .clk_pol(clk_pol), .free_run(free_run), .halt_in(halt_in),
        .wr_en(wr_en), .wr_data(wr_data), .sdata(sdata), .req(req), .sync_err(sync_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // reference model: bit queue
    bit          m_bq, m_fq, m_sd, m_err, m_full, m_armed, m_infr, m_pend, m_slot;
    logic [31:0] m_hold, m_last;
    bit          m_q[$];

    function automatic int mlen(input logic [2:0] c);
        int t[8] = '{8, 12, 16, 20, 24, 32, 32, 32};
        return t[c];
    endfunction

    task automatic mload(input int len);
        logic [31:0] w;
        w = m_full ? m_hold : m_last;
        m_last = w;
        m_full = 1'b0;
        for (int i = len - 1; i >= 0; i--) m_q.push_back(w[i]);
    endtask

    always @(posedge clk) begin
        bit rise, fall, tick, adv, fse, acc, two, dly, ign;
        int la, lb;
        if (!rst_n) begin
            m_bq = 0; m_fq = 0; m_sd = 0; m_err = 0; m_full = 0; m_armed = 0;
            m_infr = 0; m_pend = 0; m_slot = 0; m_hold = '0; m_last = '0;
            m_q.delete();
        end else begin
            rise = bclk && !m_bq;
            fall = !bclk && m_bq;
            m_bq = bclk;
            tick = clk_pol ? fall : rise;
            adv  = tick && !(halt_in && !free_run);
            la   = mlen(tx_cfg[7:5]);
            lb   = mlen(tx_cfg[23:21]);
            two  = (tx_cfg[14:8] != 0);
            dly  = (tx_cfg[17:16] != 0);
            ign  = tx_cfg[18];
            fse  = 0;
            if (adv) begin
                fse  = fsync && !m_fq;
                m_fq = fsync;
            end
            if (!tx_run) begin
                m_armed = 0; m_infr = 0; m_pend = 0; m_sd = 0; m_err = 0;
                m_q.delete();
            end else if (!m_armed) begin
                m_armed = 1;
            end else if (adv) begin
                acc = fse && (!m_infr || !ign);
                if (acc) begin
                    if (!m_full || m_infr) m_err = 1;
                    m_infr = 1; m_slot = 0; m_q.delete();
                    if (dly) begin
                        m_pend = 1; m_sd = 0;
                    end else begin
                        m_pend = 0; mload(la); m_sd = m_q.pop_front();
                    end
                end else if (m_infr) begin
                    if (m_pend) begin
                        m_pend = 0; mload(la); m_sd = m_q.pop_front();
                    end else if (m_q.size() > 0) begin
                        m_sd = m_q.pop_front();
                    end else if (!m_slot && two) begin
                        m_slot = 1; mload(lb); m_sd = m_q.pop_front();
                    end else begin
                        m_infr = 0; m_sd = 0;
                    end
                end
            end
            if (wr_en) begin
                m_hold = wr_data;
                m_full = 1;
            end
        end
    end

    // per-clock comparison, away from the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && cmp_on && !done) begin
            check(sdata === m_sd, cur, "sdata", sdata, m_sd);
            check(req === (tx_run && !m_full), cur, "req", req, tx_run && !m_full);
            check(sync_err === m_err, cur, "sync_err", sync_err, m_err);
        end
    end

    // feeder: answers requests from a queue
    always @(negedge clk) begin
        if (feed_on && req && !wr_en && feed_q.size() > 0) begin
            wr_en   = 1'b1;
            wr_data = feed_q.pop_front();
        end else begin
            wr_en = 1'b0;
        end
    end

    function automatic logic [31:0] mkcfg(input logic [2:0] la, input logic [2:0] lb,
                                          input logic [6:0] fr, input logic [1:0] dly,
                                          input logic ign);
        logic [31:0] c = '0;
        c[7:5] = la; c[23:21] = lb; c[14:8] = fr; c[17:16] = dly; c[18] = ign;
        return c;
    endfunction

    task automatic bitp(input logic fs);
        @(negedge clk); bclk = 1'b1; fsync = fs;
        @(negedge clk);
        @(negedge clk); bclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic frame(input int nbits, input int early);
        for (int b = 0; b < nbits; b++) bitp(b == 0 || (early > 0 && b == early));
    endtask

    task automatic fill(input int n, input int seed);
        for (int k = 0; k < n; k++)
            feed_q.push_back(32'hA5C3_1E77 ^ ((k + seed) * 32'h9E37_79B9));
    endtask

    task automatic start(input logic [31:0] c, input logic pol);
        tx_run = 1'b0;
        repeat (3) bitp(1'b0);
        tx_cfg = c; clk_pol = pol;
        @(negedge clk); tx_run = 1'b1;
        repeat (3) bitp(1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sdata === 1'b0, "R1", "reset sdata", sdata, 0);
        check(req === 1'b0, "R1", "reset req", req, 0);
        check(sync_err === 1'b0, "R1", "reset sync_err", sync_err, 0);
        cmp_on = 1'b1;
        fill(400, 0);
        feed_on = 1'b1;

        cur = "R4"; start(mkcfg(3'd2, 3'd2, 7'd1, 2'd1, 1'b1), 1'b1);
        repeat (4) frame(40, 0);
        cur = "R3"; start(mkcfg(3'd2, 3'd4, 7'd1, 2'd0, 1'b1), 1'b1);
        repeat (3) frame(46, 0);
        cur = "R2"; start(mkcfg(3'd0, 3'd5, 7'd1, 2'd0, 1'b1), 1'b1);
        repeat (3) frame(48, 0);
        cur = "R2"; start(mkcfg(3'd1, 3'd3, 7'd1, 2'd1, 1'b1), 1'b1);
        repeat (3) frame(40, 0);
        cur = "R2"; start(mkcfg(3'd5, 3'd5, 7'd1, 2'd1, 1'b1), 1'b1);
        repeat (3) frame(70, 0);
        cur = "R5"; start(mkcfg(3'd2, 3'd1, 7'd1, 2'd1, 1'b1), 1'b0);
        repeat (3) frame(36, 0);
        cur = "R4"; start(mkcfg(3'd4, 3'd0, 7'd0, 2'd0, 1'b1), 1'b1);
        repeat (3) frame(30, 0);
        check(sync_err === 1'b0, "R6", "no error with fed data", sync_err, 0);

        cur = "R7"; feed_on = 1'b0;
        repeat (3) frame(30, 0);
        check(sync_err === 1'b1, "R8", "starved sync flagged", sync_err, 1);
        check(req === 1'b1, "R6", "req while empty", req, 1);
        @(negedge clk); tx_run = 1'b0;
        bitp(1'b0);
        check(sync_err === 1'b0, "R8", "error cleared by reset", sync_err, 0);
        check(sdata === 1'b0, "R1", "sdata idle in reset", sdata, 0);
        check(req === 1'b0, "R1", "req low in reset", req, 0);
        feed_on = 1'b1;

        cur = "R9"; start(mkcfg(3'd2, 3'd2, 7'd1, 2'd1, 1'b0), 1'b1);
        frame(40, 0);
        check(sync_err === 1'b0, "R9", "clean frame no error", sync_err, 0);
        frame(40, 10);
        check(sync_err === 1'b1, "R9", "restart flagged", sync_err, 1);
        frame(40, 0);
        cur = "R9"; start(mkcfg(3'd2, 3'd2, 7'd1, 2'd0, 1'b1), 1'b1);
        repeat (2) frame(40, 12);
        check(sync_err === 1'b0, "R9", "ignored early sync", sync_err, 0);

        cur = "R10"; start(mkcfg(3'd2, 3'd2, 7'd1, 2'd0, 1'b1), 1'b1);
        frame(40, 0);
        begin
            logic s0;
            for (int b = 0; b < 5; b++) bitp(b == 0);
            @(negedge clk); halt_in = 1'b1; free_run = 1'b0;
            @(negedge clk); s0 = sdata;
            repeat (6) bitp(1'b0);
            check(sdata === s0, "R10", "halted sdata", sdata, s0);
            halt_in = 1'b0;
            for (int b = 0; b < 40; b++) bitp(1'b0);
            frame(40, 0);
            halt_in = 1'b1; free_run = 1'b1;
            frame(40, 0);
            halt_in = 1'b0; free_run = 1'b0;
        end
        cur = "R11"; frame(40, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule